// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from two kinds of source and drives one interrupt line to a single processor. Hardware lines come in on a port. Software-owned lines are set and cleared through register writes. Every source carries a programmable 4-bit priority. On each cycle a comparison tree finds the pending source with the highest priority, with ties going to the lowest source number. That winner is weighed against a current-priority register. The processor line rises when the winner is strictly above the current level.

When the processor acknowledges, several things happen in that cycle. The winner's number is latched as the vector, and the current level is raised to the winner's priority. The level being replaced is pushed onto an internal stack, so handler code never has to save it. A write to the end-of-interrupt register pops the stack back into the current level. Software may also write the current level directly at any time, which leaves the stack alone.

Top module: `irq_ctrl_top`

## Requirements
- R1: The winner is the pending source with the highest priority, taken over hardware and software sources together. Software source k has vector k. Hardware line j has vector N_SW+j. The priority of source i is held at address 8+i, in bits [3:0].
- R2: When several pending sources share the top priority, the one with the lowest vector wins, whatever the order in which they became pending.
- R3: `cpu_irq_o` is a register. It is high in the cycle after a cycle in which the winner's priority was strictly greater than the current level and no acknowledge was taken. It is low when the winner's priority is equal or lower, and low after reset.
- R4: A write to address 0 sets the current level (bits [3:0]) from the next cycle on and leaves the stack untouched. If that write drops the level below a pending priority, `cpu_irq_o` rises one cycle later.
- R5: An acknowledge taken while a preemption is pending works as follows. From the next cycle `cpu_vec_o` (also readable at address 4) shows the winner's vector. The current level becomes the winner's priority. `cpu_irq_o` is low in that next cycle.
- R6: A source whose priority is 0 never raises `cpu_irq_o`, even while it is pending.
- R7: Each taken acknowledge pushes the replaced level onto a 16-entry stack. A write to address 1 pops the newest entry into the current level. The current level reads back at address 0.
- R8: A push onto a full stack is dropped and sets bit 0 of address 5, which stays set until reset. A pop from an empty stack sets the current level to 0.
- R9: A write to address 2 sets the software pending bits wherever the data has a 1. A write to address 3 clears them the same way. Address 2 reads back the pending bits.
- R10: An acknowledge with no pending preemption changes neither the vector, the current level nor the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_hw_i | input | N_HW | Level-sensitive hardware request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational on address) |
| cpu_irq_o | output | 1 | Interrupt request to the processor |
| cpu_ack_i | input | 1 | One-cycle acknowledge from the processor |
| cpu_vec_o | output | 9 | Vector captured at the last taken acknowledge |

## Verification
The bench targets several corner cases:
- Equal top priorities on two hardware lines, and on a hardware/software pair. A tree that broke ties toward the higher index would report the wrong vector.
- A pending source at priority 0. A non-strict compare would raise the line.
- A current level written equal to the winner, then one below it. An off-by-one compare would fire early or never.
- An acknowledge with nothing pending. A design that latched anyway would corrupt the vector and the stack.
- Seventeen pushes and a pop of an empty stack. These expose a wrap-around that overwrites the oldest level, or a pop that returns stale data.

Random traffic mixes all of these against a bench-side model.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 9;

  typedef struct packed {
    logic              valid;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } cand_t;
endpackage

// File: rtl/irq_arb_tree.sv
`timescale 1ns/1ps
module irq_arb_tree
  import irq_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic [N_SRC-1:0]             req_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output cand_t                        win_o
);
  localparam int LVL    = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int LEAVES = 1 << LVL;

  // node 1 is root, leaves at LEAVES+i; left child always holds lower vectors
  cand_t node [1:2*LEAVES-1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N_SRC) begin : g_real
      assign node[LEAVES+i] = '{valid: req_i[i], prio: prio_i[i], vec: VEC_W'(i)};
    end else begin : g_pad
      assign node[LEAVES+i] = '{valid: 1'b0, prio: '0, vec: '0};
    end
  end

  for (genvar n = 1; n < LEAVES; n++) begin : g_node
    // >= keeps the left (lower vector) on a tie
    assign node[n] = (node[2*n].valid &&
                      (!node[2*n+1].valid || node[2*n].prio >= node[2*n+1].prio))
                     ? node[2*n] : node[2*n+1];
  end

  assign win_o = node[1];
endmodule

// File: rtl/irq_prio_lifo.sv
`timescale 1ns/1ps
module irq_prio_lifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         ovf_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full, empty;
  logic [IDX_W-1:0] top_idx, wr_idx;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign wr_idx  = IDX_W'(cnt_q);
  assign top_o   = empty ? '0 : mem_q[top_idx];
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      if (full) begin
        ovf_q <= 1'b1;
      end else begin
        mem_q[wr_idx] <= data_i;
        cnt_q         <= cnt_q + CNT_W'(1);
      end
    end else if (pop_i && !empty) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R8
  full_push_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full) |=> (ovf_q && $stable(cnt_q)));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/irq_ctrl_top.sv
`timescale 1ns/1ps
module irq_ctrl_top
  import irq_pkg::*;
#(
  parameter int N_SW       = 16,
  parameter int N_HW       = 16,
  parameter int LIFO_DEPTH = 16,
  localparam int N_SRC     = N_SW + N_HW,
  localparam int DATA_W    = (N_SW > VEC_W) ? N_SW : VEC_W,
  localparam int PRIO_BASE = 8,
  localparam int ADDR_W    = $clog2(PRIO_BASE + N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_HW-1:0]   irq_hw_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              cpu_irq_o,
  input  logic              cpu_ack_i,
  output logic [VEC_W-1:0]  cpu_vec_o
);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SSET = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SCLR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5);

  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [N_SW-1:0]              sw_pend_q;
  logic [PRIO_W-1:0]            cur_q;
  logic [VEC_W-1:0]             ack_vec_q;
  logic                         irq_q;
  logic [N_SRC-1:0]             req;
  cand_t                        win;
  logic                         preempt, take, eoi_wr, cur_wr;
  logic [PRIO_W-1:0]            lifo_top;
  logic                         lifo_ovf;

  assign req = {irq_hw_i, sw_pend_q};

  irq_arb_tree #(.N_SRC(N_SRC)) u_arb (
    .req_i  (req),
    .prio_i (prio_q),
    .win_o  (win)
  );

  // strict compare: priority 0 can never exceed any level
  assign preempt = win.valid && (win.prio > cur_q);
  assign take    = cpu_ack_i && preempt;
  assign eoi_wr  = reg_we_i && (reg_addr_i == A_EOI);
  assign cur_wr  = reg_we_i && (reg_addr_i == A_CUR);

  irq_prio_lifo #(.DEPTH(LIFO_DEPTH), .W(PRIO_W)) u_lifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (take),
    .pop_i  (eoi_wr && !take),
    .data_i (cur_q),
    .top_o  (lifo_top),
    .ovf_o  (lifo_ovf)
  );

  // acknowledge outranks end-of-interrupt, which outranks a direct write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q     <= '0;
      ack_vec_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= preempt && !take;
      if (take) begin
        cur_q     <= win.prio;
        ack_vec_q <= win.vec;
      end else if (eoi_wr) begin
        cur_q <= lifo_top;
      end else if (cur_wr) begin
        cur_q <= reg_wdata_i[PRIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_pend_q <= '0;
    end else if (reg_we_i && reg_addr_i == A_SSET) begin
      sw_pend_q <= sw_pend_q | reg_wdata_i[N_SW-1:0];
    end else if (reg_we_i && reg_addr_i == A_SCLR) begin
      sw_pend_q <= sw_pend_q & ~reg_wdata_i[N_SW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
    end else if (reg_we_i) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (reg_addr_i == ADDR_W'(PRIO_BASE + i)) prio_q[i] <= reg_wdata_i[PRIO_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CUR:   reg_rdata_o = DATA_W'(cur_q);
      A_SSET:  reg_rdata_o = DATA_W'(sw_pend_q);
      A_VEC:   reg_rdata_o = DATA_W'(ack_vec_q);
      A_STAT:  reg_rdata_o = DATA_W'(lifo_ovf);
      default: begin
        for (int i = 0; i < N_SRC; i++) begin
          if (reg_addr_i == ADDR_W'(PRIO_BASE + i)) reg_rdata_o = DATA_W'(prio_q[i]);
        end
      end
    endcase
  end

  assign cpu_irq_o = irq_q;
  assign cpu_vec_o = ack_vec_q;

  // independent scan of the tree's choice
  logic chk_higher, chk_tie_low, chk_any;
  always_comb begin
    chk_higher  = 1'b0;
    chk_tie_low = 1'b0;
    chk_any     = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i]) begin
        chk_any = 1'b1;
        if (prio_q[i] > win.prio) chk_higher = 1'b1;
        if (prio_q[i] == win.prio && VEC_W'(i) < win.vec) chk_tie_low = 1'b1;
      end
    end
  end

  // R1
  win_highest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win.valid == chk_any) && !chk_higher);
  // R2
  win_lowest_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_tie_low);
  // R3
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(preempt));
  // R5
  ack_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (cur_q == $past(win.prio)) && (ack_vec_q == $past(win.vec)) && !irq_q);
  // R6
  zero_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preempt |-> (win.prio != '0));
  // R10
  idle_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ack_i && !preempt) |=> $stable(ack_vec_q));
endmodule

// File: tb/irq_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_top_tb_top;
  localparam int N_SW   = 16;
  localparam int N_HW   = 16;
  localparam int N_SRC  = 32;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_HW-1:0]   irq_hw = '0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              cpu_irq;
  logic              cpu_ack = 1'b0;
  logic [8:0]        cpu_vec;

  int n_chk = 0;
  int n_bad = 0;

  int              prio_m [N_SRC];
  logic [N_SW-1:0] sw_m;
  int              cur_m, ackvec_m;
  int              stk[$];
  bit              ovf_m;
  int              last_cur;

  always #2 clk = ~clk;

  irq_ctrl_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_hw_i(irq_hw),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .cpu_irq_o(cpu_irq), .cpu_ack_i(cpu_ack),
    .cpu_vec_o(cpu_vec)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void best(input logic [N_SRC-1:0] req, output bit vld,
                               output int bp, output int bv);
    vld = 0; bp = 0; bv = 0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && (!vld || prio_m[i] > bp)) begin
        vld = 1; bp = prio_m[i]; bv = i;
      end
    end
  endfunction

  task automatic step(input logic [N_HW-1:0] hw, input bit we, input int addr,
                      input int wd, input bit ack);
    bit vld, pre, take, exp_irq;
    int bp, bv;
    @(negedge clk);
    irq_hw = hw; reg_we = we; reg_addr = ADDR_W'(addr);
    reg_wdata = DATA_W'(wd); cpu_ack = ack;
    best({hw, sw_m}, vld, bp, bv);
    pre  = vld && (bp > cur_m);
    take = ack && pre;
    @(posedge clk); #1;
    reg_we = 1'b0; cpu_ack = 1'b0;
    if (take) begin
      if (stk.size() < DEPTH) stk.push_back(cur_m); else ovf_m = 1;
      cur_m = bp; ackvec_m = bv;
    end else if (we && addr == 1) begin
      cur_m = (stk.size() > 0) ? stk.pop_back() : 0;
    end else if (we && addr == 0) begin
      cur_m = wd & 15;
    end
    if (we && addr == 2) sw_m = sw_m | N_SW'(wd);
    if (we && addr == 3) sw_m = sw_m & ~N_SW'(wd);
    if (we && addr >= 8 && addr < 8 + N_SRC) prio_m[addr-8] = wd & 15;
    exp_irq = pre && !take;
    check(cpu_irq === exp_irq, "R3 irq", int'(cpu_irq), int'(exp_irq));
    check(int'(cpu_vec) == ackvec_m, "R5 vector", int'(cpu_vec), ackvec_m);
    reg_addr = ADDR_W'(0); #0.1;
    last_cur = int'(reg_rdata);
    check(last_cur == cur_m, "R7 current level", last_cur, cur_m);
    reg_addr = ADDR_W'(2); #0.1;
    check(reg_rdata == DATA_W'(sw_m), "R9 sw pending", int'(reg_rdata), int'(sw_m));
    reg_addr = ADDR_W'(5); #0.1;
    check(reg_rdata[0] == ovf_m, "R8 overflow flag", int'(reg_rdata[0]), int'(ovf_m));
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N_SRC; i++) prio_m[i] = 0;
    sw_m = '0; cur_m = 0; ackvec_m = 0; ovf_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.1;
    check(cpu_irq == 1'b0, "R3 reset irq", int'(cpu_irq), 0);
    check(cpu_vec == '0, "R5 reset vector", int'(cpu_vec), 0);
    check(reg_rdata == '0, "R7 reset level", int'(reg_rdata), 0);

    // R6: every line pending at priority 0
    step('1, 0, 0, 0, 0);
    step('1, 0, 0, 0, 1);
    check(cpu_irq == 1'b0, "R6 zero priority", int'(cpu_irq), 0);

    // R1: sw source 2 at 9 beats hw source 20 at 3
    step('0, 1, 8 + 20, 3, 0);
    step('0, 1, 8 + 2, 9, 0);
    step('0, 1, 2, 1 << 2, 0);
    step(16'h0010, 0, 0, 0, 0);
    check(cpu_irq == 1'b1, "R3 raise", int'(cpu_irq), 1);
    step(16'h0010, 0, 0, 0, 1);
    check(cpu_vec == 9'd2, "R1 winner", int'(cpu_vec), 2);
    check(last_cur == 9, "R5 level loaded", last_cur, 9);
    check(cpu_irq == 1'b0, "R5 irq drops", int'(cpu_irq), 0);

    // R2: hw sources 18 and 25 tie at 12
    step('0, 1, 3, 1 << 2, 0);
    step('0, 1, 8 + 25, 12, 0);
    step('0, 1, 8 + 18, 12, 0);
    step(16'h0204, 0, 0, 0, 1);
    check(cpu_vec == 9'd18, "R2 tie lowest", int'(cpu_vec), 18);

    // R10: acknowledge with nothing pending
    step('0, 0, 0, 0, 1);
    check(cpu_vec == 9'd18 && last_cur == 12, "R10 idle ack", int'(cpu_vec), 18);

    // R4: equal level holds off, one below fires
    step(16'h0200, 1, 0, 12, 0);
    step(16'h0200, 0, 0, 0, 0);
    check(cpu_irq == 1'b0, "R4 equal level", int'(cpu_irq), 0);
    step(16'h0200, 1, 0, 11, 0);
    step(16'h0200, 0, 0, 0, 0);
    check(cpu_irq == 1'b1, "R4 lowered level", int'(cpu_irq), 1);

    // R7: pops restore 9 then 0; R8 empty pop gives 0
    step('0, 1, 1, 0, 0);
    check(last_cur == 9, "R7 pop", last_cur, 9);
    step('0, 1, 1, 0, 0);
    check(last_cur == 0, "R7 pop base", last_cur, 0);
    step('0, 1, 0, 7, 0);
    step('0, 1, 1, 0, 0);
    check(last_cur == 0, "R8 empty pop", last_cur, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [N_HW-1:0] hw;
      op = int'($urandom % 16);
      hw = N_HW'($urandom & $urandom & $urandom);
      case (op)
        0, 1, 2, 3: step(hw, 0, 0, 0, 1);
        4:          step(hw, 1, 1, 0, 0);
        5:          step(hw, 1, 0, int'($urandom % 16), 0);
        6, 7:       step(hw, 1, 8 + int'($urandom % N_SRC), int'($urandom % 16), 0);
        8:          step(hw, 1, 2, int'($urandom % 65536) & int'($urandom % 65536), 0);
        9:          step(hw, 1, 3, int'($urandom % 65536), 0);
        default:    step(hw, 0, 0, 0, 0);
      endcase
    end

    // R8: drain, then seventeen pushes
    for (int n = 0; n < DEPTH + 2; n++) step('0, 1, 1, 0, 0);
    step('0, 1, 3, 16'hffff, 0);
    for (int i = 0; i < N_SRC; i++) step('0, 1, 8 + i, 0, 0);
    step('0, 1, 8 + 0, 5, 0);
    step('0, 1, 2, 1, 0);
    for (int n = 0; n < DEPTH + 1; n++) begin
      step('0, 1, 0, 0, 0);
      step('0, 0, 0, 0, 1);
      check(cpu_vec == 9'd0 && last_cur == 5, "R8 push", last_cur, 5);
    end
    check(ovf_m == 1'b1, "R8 model overflow", int'(ovf_m), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule